// File: doc/BRIEF.md
# MD5 Compression Engine

This block performs a single MD5 compression: from a 128-bit chaining value and one 512-bit message block it produces the next 128-bit chaining value. It is iterative and completes one of the 64 steps on each clock cycle. A caller drives the seed and the block, pulses `start` while the engine is idle, and waits for the one-cycle `done` pulse. `digest_out` holds the result from that pulse until the next run completes.

The step datapath is reordered to shorten the loop. The sum of the register that is about to be replaced, the selected message word and the step constant does not depend on the word the current step produces. That sum is therefore formed one cycle early and held in a register. The step-to-step path is then one add of the logical function, a rotation, and one add of the previous word. Padding, length encoding and chaining across blocks belong to the caller.

Top module: `md5_compress`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy` and `done` are 0 and `digest_out` is 0.
- R2: A `start` high on a clock edge while `busy` is 0 is accepted, and `busy` reads 1 after that edge.
- R3: `done` is high for exactly one cycle. It becomes high on the 64th rising edge after the edge that accepted `start`, and `busy` returns to 0 on that same edge.
- R4: With `seed_in` packed as words {D,C,B,A} (A in bits 31:0) and `block_in` carrying message word j in bits 32j+31:32j (bytes little-endian inside each word), `digest_out` at `done` equals the MD5 compression of that block under that seed, packed the same way. The empty-message block gives d41d8cd98f00b204e9800998ecf8427e in byte order, and "abc" gives 900150983cd24fb0d6963f7d28e17f72.
- R5: A `start` that arrives while `busy` is 1 is ignored. The running result and the cycle on which `done` arrives do not change.
- R6: `seed_in` and `block_in` are sampled only on the accepting edge. Changes to them while `busy` is 1 do not affect the result.
- R7: `digest_out` stays unchanged after `done` until the next run completes.
- R8: A `start` presented in the cycle right after `done` is accepted, so runs can be issued back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a compression when idle |
| seed_in | input | 128 | Incoming chaining value {D,C,B,A} |
| block_in | input | 512 | Message block, word 0 in the low bits |
| busy | output | 1 | Compression in progress |
| done | output | 1 | One-cycle pulse: result valid |
| digest_out | output | 128 | Outgoing chaining value {D,C,B,A} |

## Verification
`busy` is due one edge after the accepting edge. `done` and the digest are due exactly 64 edges after it. The bench drives inputs on falling edges and counts falling edges from acceptance, then requires `done` on exactly the 64th and compares the digest there. It does not wait on `done` with an open-ended wait. Expected digests come from a behavioural model in the bench that computes its sine constants at run time. That model is first checked against two published digests. The hold and back-to-back cases are sampled at fixed offsets after `done`.

// File: rtl/md5_pkg.sv
package md5_pkg;
    parameter int WORD_W   = 32;
    parameter int N_WORDS  = 16;
    parameter int N_STEPS  = 64;
    localparam int BLOCK_W = WORD_W * N_WORDS;
    localparam int STEP_W  = $clog2(N_STEPS);
    localparam int IDX_W   = $clog2(N_WORDS);
    localparam int ROT_W   = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;

    // packed high to low so that lane a sits in the least significant bits
    typedef struct packed {
        word_t d;
        word_t c;
        word_t b;
        word_t a;
    } quad_t;

    function automatic word_t mix_fn(input logic [1:0] rnd, input word_t b,
                                     input word_t c, input word_t d);
        case (rnd)
            2'd0:    return (b & c) | (~b & d);
            2'd1:    return (b & d) | (c & ~d);
            2'd2:    return b ^ c ^ d;
            default: return c ^ (b | ~d);
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] word_sel(input logic [STEP_W-1:0] st);
        logic [IDX_W-1:0] i;
        i = st[IDX_W-1:0];
        case (st[STEP_W-1:STEP_W-2])
            2'd0:    return i;
            2'd1:    return i * 4'd5 + 4'd1;
            2'd2:    return i * 4'd3 + 4'd5;
            default: return i * 4'd7;
        endcase
    endfunction

    function automatic logic [ROT_W-1:0] rot_amt(input logic [STEP_W-1:0] st);
        case ({st[STEP_W-1:STEP_W-2], st[1:0]})
            4'h0: return 5'd7;   4'h1: return 5'd12;  4'h2: return 5'd17;  4'h3: return 5'd22;
            4'h4: return 5'd5;   4'h5: return 5'd9;   4'h6: return 5'd14;  4'h7: return 5'd20;
            4'h8: return 5'd4;   4'h9: return 5'd11;  4'hA: return 5'd16;  4'hB: return 5'd23;
            4'hC: return 5'd6;   4'hD: return 5'd10;  4'hE: return 5'd15;  default: return 5'd21;
        endcase
    endfunction
endpackage

// File: rtl/md5_const_rom.sv
module md5_const_rom
    import md5_pkg::*;
(
    input  logic [STEP_W-1:0] idx,
    output word_t             kval
);
    always_comb begin
        case (idx)
            6'd0:  kval = 32'hd76aa478; 6'd1:  kval = 32'he8c7b756; 6'd2:  kval = 32'h242070db; 6'd3:  kval = 32'hc1bdceee;
            6'd4:  kval = 32'hf57c0faf; 6'd5:  kval = 32'h4787c62a; 6'd6:  kval = 32'ha8304613; 6'd7:  kval = 32'hfd469501;
            6'd8:  kval = 32'h698098d8; 6'd9:  kval = 32'h8b44f7af; 6'd10: kval = 32'hffff5bb1; 6'd11: kval = 32'h895cd7be;
            6'd12: kval = 32'h6b901122; 6'd13: kval = 32'hfd987193; 6'd14: kval = 32'ha679438e; 6'd15: kval = 32'h49b40821;
            6'd16: kval = 32'hf61e2562; 6'd17: kval = 32'hc040b340; 6'd18: kval = 32'h265e5a51; 6'd19: kval = 32'he9b6c7aa;
            6'd20: kval = 32'hd62f105d; 6'd21: kval = 32'h02441453; 6'd22: kval = 32'hd8a1e681; 6'd23: kval = 32'he7d3fbc8;
            6'd24: kval = 32'h21e1cde6; 6'd25: kval = 32'hc33707d6; 6'd26: kval = 32'hf4d50d87; 6'd27: kval = 32'h455a14ed;
            6'd28: kval = 32'ha9e3e905; 6'd29: kval = 32'hfcefa3f8; 6'd30: kval = 32'h676f02d9; 6'd31: kval = 32'h8d2a4c8a;
            6'd32: kval = 32'hfffa3942; 6'd33: kval = 32'h8771f681; 6'd34: kval = 32'h6d9d6122; 6'd35: kval = 32'hfde5380c;
            6'd36: kval = 32'ha4beea44; 6'd37: kval = 32'h4bdecfa9; 6'd38: kval = 32'hf6bb4b60; 6'd39: kval = 32'hbebfbc70;
            6'd40: kval = 32'h289b7ec6; 6'd41: kval = 32'heaa127fa; 6'd42: kval = 32'hd4ef3085; 6'd43: kval = 32'h04881d05;
            6'd44: kval = 32'hd9d4d039; 6'd45: kval = 32'he6db99e5; 6'd46: kval = 32'h1fa27cf8; 6'd47: kval = 32'hc4ac5665;
            6'd48: kval = 32'hf4292244; 6'd49: kval = 32'h432aff97; 6'd50: kval = 32'hab9423a7; 6'd51: kval = 32'hfc93a039;
            6'd52: kval = 32'h655b59c3; 6'd53: kval = 32'h8f0ccc92; 6'd54: kval = 32'hffeff47d; 6'd55: kval = 32'h85845dd1;
            6'd56: kval = 32'h6fa87e4f; 6'd57: kval = 32'hfe2ce6e0; 6'd58: kval = 32'ha3014314; 6'd59: kval = 32'h4e0811a1;
            6'd60: kval = 32'hf7537e82; 6'd61: kval = 32'hbd3af235; 6'd62: kval = 32'h2ad7d2bb; default: kval = 32'heb86d391;
        endcase
    end
endmodule

// File: rtl/md5_word_pick.sv
module md5_word_pick
    import md5_pkg::*;
(
    input  logic [BLOCK_W-1:0] blk,
    input  logic [IDX_W-1:0]   sel,
    output word_t              word
);
    word_t lanes [N_WORDS];
    for (genvar g = 0; g < N_WORDS; g++) begin : g_lane
        assign lanes[g] = blk[g*WORD_W +: WORD_W];
    end
    assign word = lanes[sel];
endmodule

// File: rtl/md5_step_unit.sv
module md5_step_unit
    import md5_pkg::*;
(
    input  logic [1:0]       rnd,
    input  logic [ROT_W-1:0] rot,
    input  word_t            pre,
    input  word_t            b,
    input  word_t            c,
    input  word_t            d,
    output word_t            new_b
);
    word_t sum;
    logic [2*WORD_W-1:0] dbl;
    always_comb begin
        sum   = pre + mix_fn(rnd, b, c, d);
        dbl   = {sum, sum} << rot;
        new_b = b + dbl[2*WORD_W-1:WORD_W];
    end
endmodule

// File: rtl/md5_compress.sv
module md5_compress
    import md5_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [4*WORD_W-1:0] seed_in,
    input  logic [BLOCK_W-1:0]  block_in,
    output logic                busy,
    output logic                done,
    output logic [4*WORD_W-1:0] digest_out
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

    typedef struct packed {
        logic                busy;
        logic                done;
        logic [STEP_W-1:0]   step;
        quad_t               wk;
        quad_t               seed;
        logic [BLOCK_W-1:0]  block;
        word_t               pre;
        quad_t               digest;
    } state_t;

    state_t s_d, s_q;

    logic [STEP_W-1:0]  nxt_idx;
    logic [BLOCK_W-1:0] blk_src;
    word_t              x_nxt, k_nxt, new_b, a_src;
    quad_t              seed_w, fin;

    assign seed_w  = quad_t'(seed_in);
    assign nxt_idx = s_q.busy ? s_q.step + 1'b1 : '0;
    assign blk_src = s_q.busy ? s_q.block : block_in;
    assign a_src   = s_q.busy ? s_q.wk.d : seed_w.a;

    md5_word_pick u_pick (.blk(blk_src), .sel(word_sel(nxt_idx)), .word(x_nxt));
    md5_const_rom u_rom  (.idx(nxt_idx), .kval(k_nxt));
    md5_step_unit u_step (
        .rnd  (s_q.step[STEP_W-1:STEP_W-2]),
        .rot  (rot_amt(s_q.step)),
        .pre  (s_q.pre),
        .b    (s_q.wk.b),
        .c    (s_q.wk.c),
        .d    (s_q.wk.d),
        .new_b(new_b)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        fin.a    = s_q.seed.a + s_q.wk.d;
        fin.b    = s_q.seed.b + new_b;
        fin.c    = s_q.seed.c + s_q.wk.b;
        fin.d    = s_q.seed.d + s_q.wk.c;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.step  = '0;
                s_d.wk    = seed_w;
                s_d.seed  = seed_w;
                s_d.block = block_in;
                s_d.pre   = a_src + x_nxt + k_nxt;
            end
        end else begin
            s_d.wk.a = s_q.wk.d;
            s_d.wk.b = new_b;
            s_d.wk.c = s_q.wk.b;
            s_d.wk.d = s_q.wk.c;
            s_d.pre  = a_src + x_nxt + k_nxt;
            s_d.step = s_q.step + 1'b1;
            if (s_q.step == LAST_STEP) begin
                s_d.busy   = 1'b0;
                s_d.done   = 1'b1;
                s_d.digest = fin;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = s_q.busy;
    assign done       = s_q.done;
    assign digest_out = s_q.digest;
endmodule

// File: rtl/md5_compress_chk.sv
module md5_compress_chk
    import md5_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [4*WORD_W-1:0] digest_out
);
    logic [STEP_W:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)             run_cnt <= '0;
        else if (start && !busy) run_cnt <= '0;
        else if (busy)          run_cnt <= run_cnt + 1'b1;
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == (STEP_W+1)'(N_STEPS)));
    // R3
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && run_cnt != (STEP_W+1)'(N_STEPS - 1)) |=> busy);
    // R7
    digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> $stable(digest_out));
endmodule

bind md5_compress md5_compress_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .digest_out(digest_out)
);

// File: tb/tb_md5_compress.sv
module tb_md5_compress;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] seed_in = '0;
    logic [511:0] block_in = '0;
    logic         busy, done;
    logic [127:0] digest_out;

    int n_chk = 0;
    int n_bad = 0;
    real tk [64];
    int  sh [16] = '{7,12,17,22,5,9,14,20,4,11,16,23,6,10,15,21};

    localparam logic [127:0] IV = {32'h10325476, 32'h98badcfe, 32'hefcdab89, 32'h67452301};
    // {expected, block, seed}
    localparam logic [767:0] VEC [2] = '{
        {{32'h7e42f8ec, 32'h980980e9, 32'h04b2008f, 32'hd98c1dd4},
         {480'h0, 32'h00000080}, IV},
        {{32'h727fe128, 32'h7d3f96d6, 32'hb04fd23c, 32'h98500190},
         {32'h0, 32'h00000018, 416'h0, 32'h80636261}, IV}
    };

    md5_compress dut (.clk(clk), .rst_n(rst_n), .start(start), .seed_in(seed_in),
                      .block_in(block_in), .busy(busy), .done(done), .digest_out(digest_out));

    always #5 clk = ~clk;

    function automatic logic [31:0] rol(input logic [31:0] x, input int s);
        return (x << s) | (x >> (32 - s));
    endfunction

    function automatic logic [127:0] ref_md5(input logic [127:0] sd, input logic [511:0] blk);
        logic [31:0] a, b, c, d, f, tmp, kc;
        int g;
        a = sd[31:0]; b = sd[63:32]; c = sd[95:64]; d = sd[127:96];
        for (int i = 0; i < 64; i++) begin
            case (i / 16)
                0: begin f = (b & c) | (~b & d); g = i; end
                1: begin f = (d & b) | (~d & c); g = (5*i + 1) % 16; end
                2: begin f = b ^ c ^ d;          g = (3*i + 5) % 16; end
                default: begin f = c ^ (b | ~d); g = (7*i) % 16; end
            endcase
            kc  = 32'(longint'(tk[i]));
            tmp = d; d = c; c = b;
            b   = b + rol(a + f + kc + blk[g*32 +: 32], sh[(i/16)*4 + i%4]);
            a   = tmp;
        end
        return {d + sd[127:96], c + sd[95:64], b + sd[63:32], a + sd[31:0]};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // launch a run at a falling edge; returns after the accepting edge
    task automatic kick(input logic [127:0] sd, input logic [511:0] blk);
        seed_in = sd; block_in = blk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // wait edges after acceptance, require done exactly at 64
    task automatic await_done(input string tag);
        int seen = 0;
        for (int c = 1; c <= 70; c++) begin
            @(negedge clk);
            if (done) begin seen = c; break; end
        end
        check(seen == 64, tag, 128'(seen), 128'd64);
        check(busy == 1'b0, tag, 128'(busy), 128'd0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] exp, sd2;
        logic [511:0] blk2;
        for (int i = 0; i < 64; i++) begin
            real r;
            r = $sin(real'(i + 1));
            if (r < 0.0) r = -r;
            tk[i] = $floor(r * 4294967296.0);
        end

        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0 && done == 1'b0, "R1 flags in reset", {126'h0, busy, done}, 128'h0);
        check(digest_out == '0, "R1 digest in reset", digest_out, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 flags after reset", {126'h0, busy, done}, 128'h0);

        // table of published vectors (R4)
        for (int v = 0; v < 2; v++) begin
            check(ref_md5(VEC[v][127:0], VEC[v][639:128]) == VEC[v][767:640], "R4 model vs table",
                  ref_md5(VEC[v][127:0], VEC[v][639:128]), VEC[v][767:640]);
            kick(VEC[v][127:0], VEC[v][639:128]);
            check(busy == 1'b1, "R2 busy after accept", 128'(busy), 128'd1);
            await_done("R3 done latency");
            check(digest_out == VEC[v][767:640], "R4 table digest", digest_out, VEC[v][767:640]);
            @(negedge clk);
            check(done == 1'b0, "R3 done single cycle", 128'(done), 128'd0);
        end

        // R4 varied patterns
        for (int v = 0; v < 4; v++) begin
            sd2  = {$urandom, $urandom, $urandom, $urandom};
            blk2 = '0;
            for (int w = 0; w < 16; w++) blk2[w*32 +: 32] = (v == 3) ? 32'hffffffff : $urandom;
            exp = ref_md5(sd2, blk2);
            kick(sd2, blk2);
            await_done("R4 latency");
            check(digest_out == exp, "R4 varied digest", digest_out, exp);
        end

        // R5/R6: start and input changes while busy
        sd2 = {4{32'h0badf00d}};
        blk2 = {16{32'h13579bdf}};
        exp = ref_md5(sd2, blk2);
        kick(sd2, blk2);
        repeat (20) @(negedge clk);
        seed_in = ~sd2; block_in = ~blk2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R5 still busy", 128'(busy), 128'd1);
        begin
            int seen = 0;
            for (int c = 22; c <= 70; c++) begin
                @(negedge clk);
                if (done) begin seen = c; break; end
            end
            check(seen == 64, "R5 done timing unchanged", 128'(seen), 128'd64);
        end
        check(digest_out == exp, "R6 result ignores late inputs", digest_out, exp);

        // R8 back to back, R7 hold
        sd2 = IV; blk2 = {16{32'h2468ace0}};
        exp = ref_md5(sd2, blk2);
        kick(sd2, blk2);
        check(busy == 1'b1, "R8 back-to-back accepted", 128'(busy), 128'd1);
        await_done("R8 latency");
        check(digest_out == exp, "R8 digest", digest_out, exp);
        repeat (10) @(negedge clk);
        check(digest_out == exp && done == 1'b0, "R7 digest held", digest_out, exp);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule